// File: doc/BRIEF.md
# DMA Logical Address Translator

This block maps a 32-bit logical DMA address onto a physical address. The translation goes through a local page table with one entry per 4 KB page. Each entry holds a 32-bit frame word and an owner tag. Software loads entries one at a time through a write port. A DMA engine presents logical addresses on a lookup port and receives, one clock later, either a physical address or a fault. A third port reports whether a given entry is free, meaning its owner tag is zero.

The table has no reset of its own. After a synchronous, active-high reset, a small controller sweeps every entry and sets it to the empty frame pattern 0xFF000000 with owner zero.

The controller has two states:
- `ST_CLEAR`: one entry is cleared per cycle.
- `ST_READY`: the ports are served.

Transitions:
- Reset always enters `ST_CLEAR`.
- The `SWEEP_DONE` transition moves from `ST_CLEAR` to `ST_READY` in the cycle that clears the last entry.
- `ST_READY` holds until the next reset.

In the frame word, only the low 20 bits form the physical page number. The value 0xFF000000 is reserved to mean "no mapping". A lookup that lands on such an entry faults instead of producing an address.

Top module: `dlat_translator`

## Requirements
- R1: For an accepted lookup that does not fault, `rsp_paddr` equals {frame[19:0], lk_addr[11:0]}. The frame is taken from the entry indexed by lk_addr[23:12].
- R2: A lookup with any of lk_addr[31:24] nonzero faults: `rsp_fault`=1 and `rsp_paddr`=0.
- R3: A lookup whose entry frame equals 0xFF000000 faults: `rsp_fault`=1 and `rsp_paddr`=0.
- R4: A lookup is accepted when `lk_valid` and `ready` are both high. `rsp_valid` is high in exactly the cycle after an accepted lookup.
- R5: After reset is released, `ready` stays low for 4096 cycles and rises after the 4096th clock edge. It then stays high until the next reset. Every entry is then empty with owner zero.
- R6: While `ready` is low, writes are ignored. Lookups and queries while `ready` is low produce no response.
- R7: A query accepted with `ready` high gives `q_resp_valid`=1 one cycle later. `q_free`=1 in that cycle exactly when the owner of entry `q_index` is zero.
- R8: Writing an entry that already holds a mapping replaces it. Later lookups use the new frame.
- R9: A lookup in the same cycle as a write to its entry sees the previous contents. A lookup in the next cycle sees the new contents.
- R10: Frame bits [31:20] do not affect the physical address, except through the exact empty pattern of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | Table cleared; ports are served |
| wr_en | input | 1 | Write one table entry |
| wr_index | input | 12 | Entry to write |
| wr_frame | input | 32 | Frame word to store |
| wr_owner | input | 8 | Owner tag to store (0 = free) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Translation fault |
| q_valid | input | 1 | Free-entry query request |
| q_index | input | 12 | Entry to query |
| q_resp_valid | output | 1 | Query result valid |
| q_free | output | 1 | Queried entry has owner zero |

## Verification
The hardest case to reach is a write that arrives near the end of the clear sweep. The sweep has already passed that entry, so if the write were not ignored it would survive into `ST_READY`. The stimulus times its write to entry 3 four cycles before `SWEEP_DONE`, then checks that a lookup of that page still faults. The second hard case is a write and a lookup that collide on one entry in the same cycle. The bench drives both together, then repeats the lookup alone, to see the old and then the new contents.

// File: rtl/dlat_pkg.sv
package dlat_pkg;
    localparam logic [31:0] EMPTY_FRAME = 32'hFF00_0000;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_READY = 1'b1
    } dlat_state_e;
endpackage

// File: rtl/dlat_table.sv
module dlat_table #(
    parameter int IDX_W   = 12,
    parameter int FRAME_W = 32,
    parameter int OWNER_W = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   w_idx,
    input  logic [FRAME_W-1:0] w_frame,
    input  logic [OWNER_W-1:0] w_owner,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [FRAME_W-1:0] lk_frame,
    input  logic [IDX_W-1:0]   q_idx,
    output logic [OWNER_W-1:0] q_owner
);
    localparam int DEPTH = 1 << IDX_W;

    logic [FRAME_W-1:0] frame_mem [DEPTH];
    logic [OWNER_W-1:0] owner_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            frame_mem[w_idx] <= w_frame;
            owner_mem[w_idx] <= w_owner;
        end
    end

    // reads see contents before any write at this edge
    assign lk_frame = frame_mem[lk_idx];
    assign q_owner  = owner_mem[q_idx];
endmodule

// File: rtl/dlat_init_fsm.sv
module dlat_init_fsm
    import dlat_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int FRAME_W = 32,
    parameter int OWNER_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_we,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [FRAME_W-1:0] sw_frame,
    input  logic [OWNER_W-1:0] sw_owner,
    output logic               ready,
    output logic               tbl_we,
    output logic [IDX_W-1:0]   tbl_idx,
    output logic [FRAME_W-1:0] tbl_frame,
    output logic [OWNER_W-1:0] tbl_owner
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    dlat_state_e      state, state_nx;
    logic [IDX_W-1:0] sweep_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CLEAR;
            sweep_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CLEAR)
                sweep_idx <= sweep_idx + 1'b1;
        end
    end

    always_comb begin
        state_nx  = state;
        ready     = 1'b0;
        tbl_we    = 1'b0;
        tbl_idx   = sw_idx;
        tbl_frame = sw_frame;
        tbl_owner = sw_owner;
        unique case (state)
            ST_CLEAR: begin
                tbl_we    = 1'b1;
                tbl_idx   = sweep_idx;
                tbl_frame = FRAME_W'(EMPTY_FRAME);
                tbl_owner = '0;
                if (sweep_idx == LAST_IDX)
                    state_nx = ST_READY;   // SWEEP_DONE
            end
            ST_READY: begin
                ready  = 1'b1;
                tbl_we = sw_we;
            end
        endcase
    end
endmodule

// File: rtl/dlat_resolve.sv
module dlat_resolve
    import dlat_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 12,
    parameter int FRAME_W = 32,
    parameter int OWNER_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_acc,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic [FRAME_W-1:0] lk_frame,
    input  logic               q_acc,
    input  logic [OWNER_W-1:0] q_owner,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic               rsp_fault,
    output logic               q_resp_valid,
    output logic               q_free
);
    localparam int PFN_W = ADDR_W - OFF_W;
    localparam int HI_W  = ADDR_W - OFF_W - IDX_W;

    logic             hi_bad;
    logic             empty_hit;
    logic             fault_nx;
    logic [ADDR_W-1:0] paddr_nx;

    generate
        if (HI_W > 0) begin : g_hi
            assign hi_bad = |lk_addr[ADDR_W-1:OFF_W+IDX_W];
        end else begin : g_nohi
            assign hi_bad = 1'b0;
        end
    endgenerate

    assign empty_hit = (lk_frame == FRAME_W'(EMPTY_FRAME));
    assign fault_nx  = hi_bad | empty_hit;
    assign paddr_nx  = fault_nx ? '0 : {lk_frame[PFN_W-1:0], lk_addr[OFF_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_fault    <= 1'b0;
            q_resp_valid <= 1'b0;
            q_free       <= 1'b0;
        end else begin
            rsp_valid    <= lk_acc;
            q_resp_valid <= q_acc;
            if (lk_acc) begin
                rsp_paddr <= paddr_nx;
                rsp_fault <= fault_nx;
            end
            if (q_acc)
                q_free <= (q_owner == '0);
        end
    end
endmodule

// File: rtl/dlat_translator.sv
module dlat_translator #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 12,
    parameter int FRAME_W = 32,
    parameter int OWNER_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic               ready,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_index,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [OWNER_W-1:0] wr_owner,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic               rsp_fault,
    input  logic               q_valid,
    input  logic [IDX_W-1:0]   q_index,
    output logic               q_resp_valid,
    output logic               q_free
);
    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_idx;
    logic [FRAME_W-1:0] tbl_frame;
    logic [OWNER_W-1:0] tbl_owner;
    logic [FRAME_W-1:0] lk_frame;
    logic [OWNER_W-1:0] q_owner;
    logic               lk_acc;
    logic               q_acc;

    assign lk_acc = lk_valid & ready;
    assign q_acc  = q_valid & ready;

    dlat_init_fsm #(.IDX_W(IDX_W), .FRAME_W(FRAME_W), .OWNER_W(OWNER_W)) u_fsm (
        .clk(clk), .rst(rst),
        .sw_we(wr_en), .sw_idx(wr_index), .sw_frame(wr_frame), .sw_owner(wr_owner),
        .ready(ready),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_frame(tbl_frame), .tbl_owner(tbl_owner)
    );

    dlat_table #(.IDX_W(IDX_W), .FRAME_W(FRAME_W), .OWNER_W(OWNER_W)) u_tbl (
        .clk(clk),
        .we(tbl_we), .w_idx(tbl_idx), .w_frame(tbl_frame), .w_owner(tbl_owner),
        .lk_idx(lk_addr[OFF_W+IDX_W-1:OFF_W]), .lk_frame(lk_frame),
        .q_idx(q_index), .q_owner(q_owner)
    );

    dlat_resolve #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                   .FRAME_W(FRAME_W), .OWNER_W(OWNER_W)) u_res (
        .clk(clk), .rst(rst),
        .lk_acc(lk_acc), .lk_addr(lk_addr), .lk_frame(lk_frame),
        .q_acc(q_acc), .q_owner(q_owner),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .q_resp_valid(q_resp_valid), .q_free(q_free)
    );
endmodule

// File: rtl/dlat_checker.sv
module dlat_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_fault,
    input logic              q_valid,
    input logic              q_resp_valid
);
    // R4
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ready) |=> rsp_valid);

    // R4
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid && ready));

    // R2
    high_bits_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ready && (lk_addr[ADDR_W-1:OFF_W+IDX_W] != '0)) |=> rsp_fault);

    // R2
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R1
    offset_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(lk_addr[OFF_W-1:0])));

    // R5
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R7
    query_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && ready) |=> q_resp_valid);
endmodule

bind dlat_translator dlat_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .ready(ready),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .q_valid(q_valid), .q_resp_valid(q_resp_valid)
);

// File: tb/dlat_translator_test.sv
`timescale 1ns/1ps
module dlat_translator_test;
    localparam int DEPTH = 4096;
    localparam logic [31:0] EMPTY = 32'hFF00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready;
    logic        wr_en = 1'b0;
    logic [11:0] wr_index = '0;
    logic [31:0] wr_frame = '0;
    logic [7:0]  wr_owner = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        q_valid = 1'b0;
    logic [11:0] q_index = '0;
    logic        q_resp_valid;
    logic        q_free;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dlat_translator uut (
        .clk(clk), .rst(rst), .ready(ready),
        .wr_en(wr_en), .wr_index(wr_index), .wr_frame(wr_frame), .wr_owner(wr_owner),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .q_valid(q_valid), .q_index(q_index),
        .q_resp_valid(q_resp_valid), .q_free(q_free)
    );

    // op: 0 write, 1 lookup, 2 query. For writes/queries a holds the index.
    // exp_b is the expected fault (lookup) or free flag (query).
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] frame;
        logic [7:0]  owner;
        logic [31:0] exp_pa;
        logic        exp_b;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 32'h0000_1234, 32'h0,         8'h00, 32'h0,         1'b1}, // R3 empty after reset
        '{2'd2, 32'h0000_0001, 32'h0,         8'h00, 32'h0,         1'b1}, // R7 free
        '{2'd0, 32'h0000_0001, 32'h000A_BCDE, 8'h05, 32'h0,         1'b0},
        '{2'd1, 32'h0000_1234, 32'h0,         8'h00, 32'hABCD_E234, 1'b0}, // R1
        '{2'd2, 32'h0000_0001, 32'h0,         8'h00, 32'h0,         1'b0}, // R7 owned
        '{2'd1, 32'h0100_1234, 32'h0,         8'h00, 32'h0,         1'b1}, // R2
        '{2'd0, 32'h0000_0FFF, 32'h0001_2345, 8'h80, 32'h0,         1'b0},
        '{2'd1, 32'h00FF_FFFF, 32'h0,         8'h00, 32'h1234_5FFF, 1'b0}, // R1 top page
        '{2'd1, 32'h80FF_FFFF, 32'h0,         8'h00, 32'h0,         1'b1}, // R2 bit 31
        '{2'd0, 32'h0000_0001, 32'h0000_0777, 8'h09, 32'h0,         1'b0},
        '{2'd1, 32'h0000_1000, 32'h0,         8'h00, 32'h0077_7000, 1'b0}, // R8 remap
        '{2'd0, 32'h0000_0001, 32'hFF00_0000, 8'h09, 32'h0,         1'b0},
        '{2'd1, 32'h0000_1ABC, 32'h0,         8'h00, 32'h0,         1'b1}, // R3 marked empty
        '{2'd2, 32'h0000_0001, 32'h0,         8'h00, 32'h0,         1'b0}, // R7 empty frame, owned
        '{2'd0, 32'h0000_0002, 32'h1234_5678, 8'h00, 32'h0,         1'b0},
        '{2'd1, 32'h0000_2010, 32'h0,         8'h00, 32'h4567_8010, 1'b0}  // R10 high frame bits
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] idx, input logic [31:0] fr, input logic [7:0] own);
        @(negedge clk);
        wr_en = 1'b1; wr_index = idx; wr_frame = fr; wr_owner = own;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_lookup(input string req, input logic [31:0] a,
                             input logic exp_f, input logic [31:0] exp_pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        check({req, " fault"}, {31'b0, rsp_fault}, {31'b0, exp_f});
        check({req, " paddr"}, rsp_paddr, exp_pa);
    endtask

    task automatic do_query(input string req, input logic [11:0] idx, input logic exp_free);
        @(negedge clk);
        q_valid = 1'b1; q_index = idx;
        @(negedge clk);
        q_valid = 1'b0;
        check({req, " q_resp_valid"}, {31'b0, q_resp_valid}, 32'd1);
        check({req, " q_free"}, {31'b0, q_free}, {31'b0, exp_free});
    endtask

    // Reset, then walk the sweep; a write to entry 3 and a lookup are
    // issued four cycles before the sweep ends.
    task automatic reset_and_sweep();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 ready in reset", {31'b0, ready}, 32'd0);
        check("R4 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        rst = 1'b0;
        for (int i = 1; i <= DEPTH; i++) begin
            @(negedge clk);
            if (i == DEPTH - 4) begin
                wr_en = 1'b1; wr_index = 12'd3; wr_frame = 32'h0000_0333; wr_owner = 8'h11;
                lk_valid = 1'b1; lk_addr = 32'h0000_3000;
                q_valid = 1'b1; q_index = 12'd3;
            end
            if (i == DEPTH - 3) begin
                wr_en = 1'b0; lk_valid = 1'b0; q_valid = 1'b0;
                check("R6 no rsp while clearing", {31'b0, rsp_valid}, 32'd0);
                check("R6 no query rsp while clearing", {31'b0, q_resp_valid}, 32'd0);
            end
            if (i == DEPTH - 1)
                check("R5 ready low before last edge", {31'b0, ready}, 32'd0);
        end
        check("R5 ready high after sweep", {31'b0, ready}, 32'd1);
    endtask

    logic [31:0] ref_map [int];

    initial begin : main
        reset_and_sweep();
        do_lookup("R6 write during clear ignored", 32'h0000_3000, 1'b1, 32'h0);
        do_query("R6 owner untouched", 12'd3, 1'b1);

        for (int v = 0; v < NV; v++) begin
            unique case (VECS[v].op)
                2'd0: do_write(VECS[v].a[11:0], VECS[v].frame, VECS[v].owner);
                2'd1: do_lookup("R1/R2/R3/R8/R10 vector", VECS[v].a, VECS[v].exp_b, VECS[v].exp_pa);
                default: do_query("R7 vector", VECS[v].a[11:0], VECS[v].exp_b);
            endcase
        end

        // R9: write and lookup collide on entry 5
        @(negedge clk);
        wr_en = 1'b1; wr_index = 12'd5; wr_frame = 32'h0000_0555; wr_owner = 8'h01;
        lk_valid = 1'b1; lk_addr = 32'h0000_5044;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check("R9 same-cycle sees old fault", {31'b0, rsp_fault}, 32'd1);
        check("R9 same-cycle paddr", rsp_paddr, 32'h0);
        do_lookup("R9 next cycle sees new", 32'h0000_5044, 1'b0, 32'h0055_5044);

        // R5: a second reset clears the earlier mappings
        reset_and_sweep();
        do_lookup("R5 mapping cleared", 32'h0000_5044, 1'b1, 32'h0);
        do_query("R5 owner cleared", 12'd5, 1'b1);

        // random mix against a reference map
        for (int k = 0; k < 300; k++) begin
            int unsigned sel;
            logic [11:0] idx;
            logic [31:0] fr;
            logic [31:0] a;
            logic        ef;
            logic [31:0] ep;
            sel = $urandom_range(0, 2);
            idx = 12'($urandom_range(0, 15));
            if (sel == 0) begin
                fr = ($urandom_range(0, 5) == 0) ? EMPTY : $urandom();
                ref_map[int'(idx)] = fr;
                do_write(idx, fr, 8'h01);
            end else begin
                a = {($urandom_range(0, 7) == 0) ? 8'h40 : 8'h00, idx, 12'($urandom())};
                ef = 1'b0;
                if (a[31:24] != 8'h00) ef = 1'b1;
                else if (!ref_map.exists(int'(idx))) ef = 1'b1;
                else if (ref_map[int'(idx)] == EMPTY) ef = 1'b1;
                ep = ef ? 32'h0 : {ref_map[int'(idx)][19:0], a[11:0]};
                do_lookup("R1/R2/R3/R8 random", a, ef, ep);
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule